// File: doc/BRIEF.md
# Power-Manager Interrupt Status and Acknowledge Unit

This block collects the power manager's asynchronous events into an 8-bit pending register. Each event is gated by an 8-bit enable mask. Whenever any enabled event is pending, the block pulls an active-low interrupt line. There are three event sources:

- an internal one-second tick;
- an explicit peripheral-bus reply;
- an autopoll result from the same bus.

Reply payload bytes are placed in a small buffer through a write port, before the reply is reported.

The host talks to the block through single-cycle commands that carry up to four argument bytes:

- **Acknowledge** returns status and clears it. The answer is sent as a byte stream, one byte per cycle. When a bus reply is pending, the acknowledge is selective. It returns only the bus-related status bits and the buffered payload, and it leaves the other events pending.
- **Set-mask** loads the enable mask.
- **Bus packet** with a fixed two-byte signature loads a 16-bit autopoll mask. While that mask is nonzero, the block requests a poll of the bus at a fixed interval.

Top module: `irq_ack_unit`

## Requirements
- R1: `irq_n` is 0 exactly when (pending AND mask) is nonzero. It follows any change of either register on the next clock edge.
- R2: After reset the mask is 0x18 (bus-reply bit 4 and tick bit 3), pending is 0, `irq_n` is 1 and `rsp_valid` is 0.
- R3: A tick sets pending bit 3 every TICK_MS*CYC_PER_MS cycles. Each tick follows the previous one by exactly that many cycles, so the ticks do not drift.
- R4: A `rply_done` pulse sets pending bit 4 and records `rply_len` as the payload count.
- R5: A `poll_done` result is taken only while bit 4 is clear and `poll_len` is nonzero. It then sets bits 4 and 7 and records `poll_len`. Otherwise it has no effect.
- R6: Command op 2 (bus packet) with argc 4 and with argument bytes 0 and 1 equal to 0x00 and 0x86 loads the autopoll mask {byte2, byte3}. Argument byte i sits at `cmd_args[8*i+:8]`. While this mask is nonzero, `poll_req` pulses every POLL_MS*CYC_PER_MS cycles, with the first pulse that many cycles after the command. A zero mask stops the pulses. Other bus packets have no effect.
- R7: Op 0 (acknowledge) with argc 0, while bit 4 is set, returns pending AND 0x90 followed by the payload bytes. It clears only bits 4, 7 and the count.
- R8: Acknowledge while bit 4 is clear returns one byte equal to the whole pending register, and clears the register.
- R9: Op 1 (set-mask) with argc 1 loads byte 0 into the mask. With any other argc the mask is unchanged.
- R10: An event that arrives in the same cycle as an acknowledge clear wins: its bit is set afterwards.
- R11: An acknowledge with a nonzero argc is ignored. No response is sent and nothing is cleared.
- R12: The first response byte appears the cycle after the command. Further bytes follow one per cycle, and `rsp_last` marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rbuf_we | input | 1 | Reply buffer write strobe |
| rbuf_idx | input | $clog2(BUF_DEPTH) | Reply buffer write index |
| rbuf_data | input | 8 | Reply buffer write byte |
| rply_done | input | 1 | Explicit bus reply complete |
| rply_len | input | $clog2(BUF_DEPTH+1) | Explicit reply payload length |
| poll_done | input | 1 | Autopoll result strobe |
| poll_len | input | $clog2(BUF_DEPTH+1) | Autopoll payload length |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 acknowledge, 1 set-mask, 2 bus packet |
| cmd_argc | input | 3 | Argument byte count |
| cmd_args | input | 32 | Argument bytes, byte i at [8*i+:8] |
| poll_req | output | 1 | Autopoll request pulse |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final response byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Pending, mask and payload count are registered, so event strobes and commands show at `irq_n` one cycle later. The bench drives every input at a falling edge and samples at the next falling edge, after exactly one rising edge. Acknowledge streams begin in that same sample and are then collected one byte per falling edge until `rsp_valid` drops. For the tick and autopoll periods, the bench counts falling edges from the stimulus to the `irq_n` fall or the `poll_req` pulse. To test that an event wins over a clear, an acknowledge is aimed at the cycle just before a tick is due, using a cycle counter that starts from the previous tick.

// File: rtl/pmirq_pkg.sv
package pmirq_pkg;
    typedef enum logic [1:0] {
        OP_ACK     = 2'd0,
        OP_SETMASK = 2'd1,
        OP_BUSPKT  = 2'd2
    } op_e;

    localparam int EV_TICK = 3;
    localparam int EV_BUS  = 4;
    localparam int EV_AUTO = 7;

    localparam logic [7:0] MASK_AT_RESET = 8'h18;
    localparam logic [7:0] BUS_BITS      = 8'h90;
    localparam logic [7:0] AP_SIG0       = 8'h00;
    localparam logic [7:0] AP_SIG1       = 8'h86;

    typedef struct packed {
        logic       ack_bus;
        logic       ack_all;
        logic       mask_ld;
        logic [7:0] mask_val;
    } ctl_t;

    function automatic logic is_autopoll(input op_e op, input logic [2:0] argc,
                                         input logic [31:0] args);
        return op == OP_BUSPKT && argc == 3'd4 &&
               args[7:0] == AP_SIG0 && args[15:8] == AP_SIG1;
    endfunction
endpackage

// File: rtl/pm_period_tmr.sv
module pm_period_tmr #(
    parameter int PERIOD = 30000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic fire
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;

    assign fire = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt_q <= '0;
        else if (fire)              cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pm_evt_reg.sv
module pm_evt_reg
    import pmirq_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_fire,
    input  logic          rply_done,
    input  logic [CW-1:0] rply_len,
    input  logic          poll_done,
    input  logic [CW-1:0] poll_len,
    input  ctl_t          ctl,
    output logic [7:0]    pend_q,
    output logic [7:0]    mask_q,
    output logic [CW-1:0] cnt_q
);
    logic [7:0]    pend_d;
    logic [CW-1:0] cnt_d;
    logic          poll_ok;

    assign poll_ok = poll_done && !pend_q[EV_BUS] && (poll_len != '0);

    always_comb begin
        pend_d = pend_q;
        cnt_d  = cnt_q;
        if (ctl.ack_all) pend_d = '0;
        if (ctl.ack_bus) begin
            pend_d = pend_d & ~BUS_BITS;
            cnt_d  = '0;
        end
        // new events are applied after clears so they win
        if (tick_fire) pend_d[EV_TICK] = 1'b1;
        if (rply_done) begin
            pend_d[EV_BUS] = 1'b1;
            cnt_d          = rply_len;
        end
        if (poll_ok) begin
            pend_d[EV_BUS]  = 1'b1;
            pend_d[EV_AUTO] = 1'b1;
            cnt_d           = poll_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cnt_q  <= '0;
            mask_q <= MASK_AT_RESET;
        end else begin
            pend_q <= pend_d;
            cnt_q  <= cnt_d;
            if (ctl.mask_ld) mask_q <= ctl.mask_val;
        end
    end
endmodule

// File: rtl/pm_rsp_seq.sv
module pm_rsp_seq #(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          start,
    input  logic [7:0]    status,
    input  logic [CW-1:0] nbody,
    output logic          busy,
    output logic          rsp_valid,
    output logic [7:0]    rsp_data,
    output logic          rsp_last
);
    logic [7:0]    buf_q [DEPTH];
    logic [CW-1:0] idx_q, body_q, rd;
    logic [7:0]    stat_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (wr_en) buf_q[wr_idx] <= wr_data;
    end

    assign rd        = idx_q - 1'b1;
    assign busy      = busy_q;
    assign rsp_valid = busy_q;
    assign rsp_last  = busy_q && (idx_q == body_q);
    assign rsp_data  = !busy_q ? 8'h00 :
                       (idx_q == '0) ? stat_q : buf_q[rd[IW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            body_q <= '0;
            stat_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            body_q <= nbody;
            stat_q <= status;
        end else if (busy_q) begin
            if (rsp_last) busy_q <= 1'b0;
            else          idx_q  <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import pmirq_pkg::*;
#(
    parameter int CYC_PER_MS = 1000,
    parameter int TICK_MS    = 1000,
    parameter int POLL_MS    = 30,
    parameter int BUF_DEPTH  = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rbuf_we,
    input  logic [$clog2(BUF_DEPTH)-1:0]   rbuf_idx,
    input  logic [7:0]                     rbuf_data,
    input  logic                           rply_done,
    input  logic [$clog2(BUF_DEPTH+1)-1:0] rply_len,
    input  logic                           poll_done,
    input  logic [$clog2(BUF_DEPTH+1)-1:0] poll_len,
    input  logic                           cmd_valid,
    input  logic [1:0]                     cmd_op,
    input  logic [2:0]                     cmd_argc,
    input  logic [31:0]                    cmd_args,
    output logic                           poll_req,
    output logic                           rsp_valid,
    output logic [7:0]                     rsp_data,
    output logic                           rsp_last,
    output logic                           irq_n
);
    localparam int IW          = $clog2(BUF_DEPTH);
    localparam int CW          = $clog2(BUF_DEPTH + 1);
    localparam int TICK_CYCLES = TICK_MS * CYC_PER_MS;
    localparam int POLL_CYCLES = POLL_MS * CYC_PER_MS;

    op_e           op;
    ctl_t          ctl;
    logic          busy, ack_ok, tick_fire, ap_ld, ap_restart;
    logic [15:0]   ap_mask_q, ap_new;
    logic [7:0]    pend_q, mask_q, status;
    logic [CW-1:0] cnt_q, nbody;

    assign op     = op_e'(cmd_op);
    assign ack_ok = cmd_valid && op == OP_ACK && cmd_argc == 3'd0 && !busy;

    always_comb begin
        ctl.ack_bus  = ack_ok && pend_q[EV_BUS];
        ctl.ack_all  = ack_ok && !pend_q[EV_BUS];
        ctl.mask_ld  = cmd_valid && op == OP_SETMASK && cmd_argc == 3'd1;
        ctl.mask_val = cmd_args[7:0];
    end

    assign status = pend_q[EV_BUS] ? (pend_q & BUS_BITS) : pend_q;
    assign nbody  = pend_q[EV_BUS] ? cnt_q : '0;

    // autopoll mask: loaded from the signed bus packet, restart only on change
    assign ap_ld      = cmd_valid && is_autopoll(op, cmd_argc, cmd_args);
    assign ap_new     = {cmd_args[23:16], cmd_args[31:24]};
    assign ap_restart = ap_ld && (ap_new != ap_mask_q);

    always_ff @(posedge clk) begin
        if (rst)        ap_mask_q <= '0;
        else if (ap_ld) ap_mask_q <= ap_new;
    end

    pm_period_tmr #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk(clk), .rst(rst), .run(1'b1), .restart(1'b0), .fire(tick_fire)
    );

    pm_period_tmr #(.PERIOD(POLL_CYCLES)) u_poll (
        .clk(clk), .rst(rst), .run(ap_mask_q != '0), .restart(ap_restart),
        .fire(poll_req)
    );

    pm_evt_reg #(.CW(CW)) u_evt (
        .clk(clk), .rst(rst), .tick_fire(tick_fire),
        .rply_done(rply_done), .rply_len(rply_len),
        .poll_done(poll_done), .poll_len(poll_len), .ctl(ctl),
        .pend_q(pend_q), .mask_q(mask_q), .cnt_q(cnt_q)
    );

    pm_rsp_seq #(.DEPTH(BUF_DEPTH), .CW(CW), .IW(IW)) u_rsp (
        .clk(clk), .rst(rst), .wr_en(rbuf_we), .wr_idx(rbuf_idx),
        .wr_data(rbuf_data), .start(ack_ok), .status(status), .nbody(nbody),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_last(rsp_last)
    );

    assign irq_n = ~|(pend_q & mask_q);
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk
    import pmirq_pkg::*;
#(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          irq_n,
    input logic          rsp_valid,
    input logic          rsp_last,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic [2:0]    cmd_argc,
    input logic          ack_ok,
    input logic          pend_bus,
    input logic          tick_fire,
    input logic          rply_done,
    input logic          poll_done,
    input logic [7:0]    pend_q,
    input logic [7:0]    mask_q,
    input logic [CW-1:0] cnt_q
);
    a_r2_reset_irq_high: assert property (@(posedge clk)
        $past(rst) |-> irq_n);

    a_r10_tick_wins: assert property (@(posedge clk) disable iff (rst)
        tick_fire |=> pend_q[EV_TICK]);

    a_r7_ack_selective: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && pend_bus && !rply_done && !poll_done) |=>
        (!pend_q[EV_BUS] && !pend_q[EV_AUTO] && cnt_q == '0 &&
         (pend_q & ~BUS_BITS) ==
         (($past(pend_q) & ~BUS_BITS) | ($past(tick_fire) ? 8'h08 : 8'h00))));

    a_r8_ack_all: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && !pend_bus && !tick_fire && !rply_done && !poll_done) |=>
        pend_q == 8'h00);

    a_r9_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1 && cmd_argc != 3'd1) |=> $stable(mask_q));

    a_r5_poll_blocked: assert property (@(posedge clk) disable iff (rst)
        (poll_done && pend_bus && !ack_ok && !rply_done) |=>
        ($stable(cnt_q) && pend_q[EV_BUS]));

    a_r11_bad_ack: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd0 && cmd_argc != 3'd0 && !rsp_valid) |=>
        !rsp_valid);

    a_r12_last_in_stream: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);
endmodule

bind irq_ack_unit irq_ack_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .irq_n(irq_n), .rsp_valid(rsp_valid),
    .rsp_last(rsp_last), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_argc(cmd_argc), .ack_ok(ack_ok), .pend_bus(pend_q[4]),
    .tick_fire(tick_fire), .rply_done(rply_done), .poll_done(poll_done),
    .pend_q(pend_q), .mask_q(mask_q), .cnt_q(cnt_q)
);

// File: tb/sim_irq_ack_unit.sv
module sim_irq_ack_unit;
    localparam int CPM  = 4;
    localparam int TICK = 1000 * CPM;
    localparam int POLL = 30 * CPM;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rbuf_we = 1'b0;
    logic [2:0]  rbuf_idx = '0;
    logic [7:0]  rbuf_data = '0;
    logic        rply_done = 1'b0;
    logic [3:0]  rply_len = '0;
    logic        poll_done = 1'b0;
    logic [3:0]  poll_len = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_argc = '0;
    logic [31:0] cmd_args = '0;
    logic        poll_req, rsp_valid, rsp_last, irq_n;
    logic [7:0]  rsp_data;

    int nchk = 0, nerr = 0, cyc = 0, ngot = 0, lastpos = -1;
    logic [7:0] got [16];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_ack_unit #(.CYC_PER_MS(CPM)) u0 (
        .clk(clk), .rst(rst), .rbuf_we(rbuf_we), .rbuf_idx(rbuf_idx),
        .rbuf_data(rbuf_data), .rply_done(rply_done), .rply_len(rply_len),
        .poll_done(poll_done), .poll_len(poll_len), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_argc(cmd_argc), .cmd_args(cmd_args),
        .poll_req(poll_req), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [2:0] argc, input logic [31:0] args);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_argc = argc; cmd_args = args;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ack_now(input logic [2:0] argc);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_argc = argc; cmd_args = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        ngot = 0; lastpos = -1;
        while (rsp_valid && ngot < 16) begin
            got[ngot] = rsp_data;
            if (rsp_last) lastpos = ngot;
            ngot++;
            @(negedge clk);
        end
    endtask

    task automatic ack(input logic [2:0] argc);
        @(negedge clk);
        ack_now(argc);
    endtask

    task automatic put_bytes(input int n, input logic [23:0] b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rbuf_we = 1'b1; rbuf_idx = 3'(i); rbuf_data = b[8*i +: 8];
        end
        @(negedge clk);
        rbuf_we = 1'b0;
    endtask

    task automatic pulse_reply(input bit is_poll, input int n);
        @(negedge clk);
        if (is_poll) begin poll_done = 1'b1; poll_len = 4'(n); end
        else begin rply_done = 1'b1; rply_len = 4'(n); end
        @(negedge clk);
        poll_done = 1'b0; rply_done = 1'b0;
    endtask

    task automatic t_reset;
        chk("R2 irq_n after reset", irq_n, 1);
        chk("R2 rsp_valid after reset", rsp_valid, 0);
    endtask

    task automatic t_explicit;
        put_bytes(3, 24'hC3B2A1);
        pulse_reply(0, 3);
        chk("R4/R1 irq_n low on reply", irq_n, 0);
        ack(0);
        chk("R12 stream length", ngot, 4);
        chk("R7 status byte", got[0], 8'h10);
        chk("R7 payload 0", got[1], 8'hA1);
        chk("R7 payload 2", got[3], 8'hC3);
        chk("R12 last marker", lastpos, 3);
        chk("R1 irq_n high after ack", irq_n, 1);
    endtask

    task automatic t_bad_ack;
        put_bytes(1, 24'h000011);
        pulse_reply(0, 1);
        ack(1);
        chk("R11 no response", ngot, 0);
        chk("R11 irq still low", irq_n, 0);
        ack(0);
        chk("R11 later ack works", ngot, 2);
    endtask

    task automatic t_poll;
        put_bytes(2, 24'h006655);
        pulse_reply(1, 2);
        chk("R5 poll sets irq", irq_n, 0);
        ack(0);
        chk("R5 status bits 4 and 7", got[0], 8'h90);
        chk("R5 poll payload", got[2], 8'h66);
        pulse_reply(1, 0);
        chk("R5 zero-length poll ignored", irq_n, 1);
        put_bytes(1, 24'h000077);
        pulse_reply(0, 1);
        pulse_reply(1, 3);
        ack(0);
        chk("R5 blocked poll length", ngot, 2);
        chk("R5 blocked poll status", got[0], 8'h10);
        chk("R5 blocked poll payload", got[1], 8'h77);
    endtask

    task automatic t_mask;
        send(2'd1, 3'd2, 32'h0);
        pulse_reply(0, 0);
        chk("R9 bad-length set-mask ignored", irq_n, 0);
        ack(0);
        send(2'd1, 3'd1, 32'h80);
        pulse_reply(0, 0);
        chk("R9/R1 bus bit masked", irq_n, 1);
        ack(0);
        chk("R7 empty payload response", ngot, 1);
        chk("R7 empty payload status", got[0], 8'h10);
        put_bytes(1, 24'h000001);
        pulse_reply(1, 1);
        chk("R9/R1 auto bit enabled", irq_n, 0);
        ack(0);
        send(2'd1, 3'd1, 32'h08);
    endtask

    task automatic t_autopoll;
        int n;
        send(2'd2, 3'd4, {8'h01, 8'h00, 8'h86, 8'h00});
        n = 1;
        while (!poll_req && n < 3 * POLL) begin @(negedge clk); n++; end
        chk("R6 first poll delay", n, POLL);
        @(negedge clk); n = 1;
        while (!poll_req && n < 3 * POLL) begin @(negedge clk); n++; end
        chk("R6 poll period", n, POLL);
        send(2'd2, 3'd4, {8'h00, 8'h00, 8'h87, 8'h00});
        n = 1;
        while (!poll_req && n < 3 * POLL) begin @(negedge clk); n++; end
        chk("R6 unsigned packet keeps polling", n < POLL + 1, 1);
        send(2'd2, 3'd4, {8'h00, 8'h00, 8'h86, 8'h00});
        n = 0;
        for (int i = 0; i < 2 * POLL; i++) begin
            @(negedge clk);
            if (poll_req) n++;
        end
        chk("R6 zero mask stops polling", n, 0);
    endtask

    task automatic t_tick;
        int e, early;
        ack(0);
        while (irq_n) @(negedge clk);
        e = cyc;
        ack_now(0);
        chk("R8 tick-only ack", got[0] & 8'h08, 8'h08);
        chk("R8 tick cleared", irq_n, 1);
        early = 0;
        while (cyc < e + TICK - 1) begin
            if (!irq_n) early = 1;
            @(negedge clk);
        end
        chk("R3 no early tick", early, 0);
        ack_now(0);
        chk("R10 ack sees empty pending", got[0], 8'h00);
        chk("R3/R10 tick lands and wins", irq_n, 0);
        put_bytes(1, 24'h00003C);
        pulse_reply(0, 1);
        ack(0);
        chk("R7 selective status", got[0], 8'h10);
        chk("R7 selective payload", got[1], 8'h3C);
        chk("R7 tick still pending", irq_n, 0);
        ack(0);
        chk("R8 remaining tick", got[0], 8'h08);
        chk("R8 all cleared", irq_n, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_explicit;
        t_bad_ack;
        t_poll;
        t_mask;
        t_autopoll;
        t_tick;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #(200000 * 10);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule